// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block is an eight-stage shift register. A byte presented on the parallel inputs is captured into the stages. It is then shifted out one bit at a time from the last stage, which is offered both true and inverted. Each shift moves every stage one step towards the last stage, and the serial input fills the first stage.

Shifting is driven by two clock pins that are interchangeable. Either pin can act as the clock while the other, held high, blocks it. An active-low load pin overrides everything else. While it is low, the stages copy the parallel inputs and ignore the clock pins and the serial input.

The block runs synchronously on a fast system clock. Every external pin passes through a two-flop synchronizer. Edges on the clock pins are found by comparing the synchronized sample with the one before it, so each external edge gives exactly one shift. The stage contents are brought out so they can be observed.

Top module: `piso_gated`

## Requirements
- R1: After reset, all stages read 0, `ser_out` is 0 and `ser_out_n` is 1.
- R2: While `load_n` is low, `stage_q[i]` follows `par_in[i]` for every i, and keeps doing so for as long as the pin stays low. This holds whatever the clock pins and `ser_in` do.
- R3: While `load_n` is high, changes on `par_in` leave the stages unchanged.
- R4: With `load_n` high, a low-to-high change on one clock pin while the other pin is steadily low performs one shift. In a shift, stage 0 takes `ser_in` and stage i takes the old value of stage i-1.
- R5: While either clock pin is high, rises and falls of the other pin cause no shift. This includes raising the inhibiting pin while the clock pin is high.
- R6: With `load_n` high and both clock pins steadily low, the stages hold their values.
- R7: If both clock pins rise in the same synchronized sample, no shift occurs.
- R8: `ser_out` equals stage 7 and `ser_out_n` is its inverse at all times.
- R9: A pin change takes effect on the stages no later than three system clocks after it. One external clock edge produces exactly one shift, however long the pins are then held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| load_n | input | 1 | Active-low parallel load |
| sclk_a | input | 1 | Clock pin A (can also act as inhibit) |
| sclk_b | input | 1 | Clock pin B (can also act as inhibit) |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel data, bit i to stage i |
| stage_q | output | 8 | Current stage contents |
| ser_out | output | 1 | Last stage, true |
| ser_out_n | output | 1 | Last stage, inverted |

## Verification
The assertions check on every system clock that a low load copies the synchronized parallel byte into the stages. They also check that each detected edge shifts by exactly one position with the synchronized serial bit, and that a pin held high freezes the stages whatever the other pin does. The complementary outputs are checked each cycle. Other behaviours can only be shown by the bench's scenarios, as external pin sequences: the end-to-end latency, the single shift per long pulse, and raising the inhibit while the clock is high. The same applies to loading while the clock pins toggle, and to the simultaneous rise of both pins.

// File: rtl/piso_gated.sv
module piso_gated #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             sclk_a,
  input  logic             sclk_b,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] stage_q,
  output logic             ser_out,
  output logic             ser_out_n
);

  logic [1:0]       ld_sy, ca_sy, cb_sy, si_sy;
  logic [WIDTH-1:0] par_m, par_s;
  logic             ca_p, cb_p;
  logic [WIDTH-1:0] stage;

  wire ld = ld_sy[1];
  wire ca = ca_sy[1];
  wire cb = cb_sy[1];
  wire si = si_sy[1];

  // one pin rises while the other stays low
  wire edge_a = ca & ~ca_p & ~cb & ~cb_p;
  wire edge_b = cb & ~cb_p & ~ca & ~ca_p;
  wire shift  = ld & (edge_a | edge_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_sy <= 2'b11;
      ca_sy <= 2'b11;
      cb_sy <= 2'b11;
      si_sy <= 2'b00;
      par_m <= '0;
      par_s <= '0;
      ca_p  <= 1'b1;
      cb_p  <= 1'b1;
      stage <= '0;
    end else begin
      ld_sy <= {ld_sy[0], load_n};
      ca_sy <= {ca_sy[0], sclk_a};
      cb_sy <= {cb_sy[0], sclk_b};
      si_sy <= {si_sy[0], ser_in};
      par_m <= par_in;
      par_s <= par_m;
      ca_p  <= ca;
      cb_p  <= cb;
      if (!ld)
        stage <= par_s;
      else if (shift)
        stage <= {stage[WIDTH-2:0], si};
    end
  end

  assign stage_q   = stage;
  assign ser_out   = stage[WIDTH-1];
  assign ser_out_n = ~stage[WIDTH-1];

  a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> stage == $past(par_s));

  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> stage == {$past(stage[WIDTH-2:0]), $past(si)});

  a_r5_a_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ca && ca_p) |=> $stable(stage));

  a_r5_b_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && cb && cb_p) |=> $stable(stage));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ca && !ca_p && !cb && !cb_p) |=> $stable(stage));

  a_r8_complement: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out_n != ser_out);

endmodule

// File: tb/piso_gated_tb.sv
`timescale 1ns/1ps
module piso_gated_tb;
  logic clk = 0, rst_n = 0;
  logic load_n = 1, sclk_a = 0, sclk_b = 0, ser_in = 0;
  logic [7:0] par_in = 0;
  logic [7:0] stage_q;
  logic ser_out, ser_out_n;
  int errors = 0, checks = 0;
  logic [7:0] exp_q = 0;
  bit done = 0;

  piso_gated u_dut (.clk(clk), .rst_n(rst_n), .load_n(load_n), .sclk_a(sclk_a),
    .sclk_b(sclk_b), .ser_in(ser_in), .par_in(par_in), .stage_q(stage_q),
    .ser_out(ser_out), .ser_out_n(ser_out_n));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] shifted(logic [7:0] q, logic b);
    return {q[6:0], b};
  endfunction

  task automatic settle(int n = 6);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag);
    checks++;
    if (stage_q !== exp_q || ser_out !== exp_q[7] || ser_out_n !== ~exp_q[7]) begin
      errors++;
      $display("FAIL %s: stage=%h out=%b outn=%b expected stage=%h out=%b outn=%b",
               tag, stage_q, ser_out, ser_out_n, exp_q, exp_q[7], ~exp_q[7]);
    end
  endtask

  task automatic do_load(logic [7:0] v);
    par_in = v; load_n = 0; settle(); exp_q = v; check("R2 load");
    load_n = 1; settle();
  endtask

  task automatic pulse(bit use_b, logic b);
    ser_in = b;
    if (use_b) sclk_b = 1; else sclk_a = 1;
    settle(3); exp_q = shifted(exp_q, b); check("R9 latency"); // within 3 clocks
    settle(10); check("R9 single shift");
    ser_in = ~b;
    if (use_b) sclk_b = 0; else sclk_a = 0;
    settle(); check("R4 shift");
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0165));
    settle(3); exp_q = 0; check("R1 reset");
    rst_n = 1; settle(); check("R1 after release");

    // R2: follows while low, regardless of clocks and serial
    par_in = 8'hA5; load_n = 0; settle(); exp_q = 8'hA5; check("R2 load");
    par_in = 8'h3C; settle(); exp_q = 8'h3C; check("R2 follows");
    sclk_a = 1; ser_in = 1; settle(); sclk_a = 0; settle(); check("R2 clocks ignored");
    load_n = 1; settle();

    // R3: parallel ignored
    par_in = 8'hFF; settle(); check("R3 par ignored");

    // R4: eight shifts, known pattern, both pins
    do_load(8'b1100_1010);
    for (int i = 0; i < 8; i++) pulse(i[0], (8'h6D >> i) & 1'b1);

    // R6: idle
    settle(20); check("R6 idle hold");

    // R5: inhibit raised while clock high
    ser_in = 1; sclk_a = 1; settle(); exp_q = shifted(exp_q, 1'b1); check("R4 edge a");
    sclk_b = 1; settle(); check("R5 inhibit raised while clock high");
    sclk_a = 0; settle(); sclk_a = 1; settle(); check("R5 rise blocked");
    sclk_a = 0; settle(); sclk_b = 0; settle(); check("R5 inhibit released");
    sclk_a = 1; settle(); sclk_b = 1; settle(); sclk_a = 0; settle();
    sclk_a = 1; settle(); sclk_a = 0; settle(); sclk_b = 0; settle();
    exp_q = shifted(exp_q, 1'b1); check("R5 only one shift with b high");

    // R7: simultaneous rise
    sclk_a = 1; sclk_b = 1; settle(); check("R7 both rise");
    sclk_a = 0; sclk_b = 0; settle(); check("R7 both fall");

    // R8 / random mix
    for (int k = 0; k < 60; k++) begin
      case ($urandom % 4)
        0: do_load(8'($urandom));
        1: pulse(1'b0, 1'($urandom));
        2: pulse(1'b1, 1'($urandom));
        default: begin par_in = 8'($urandom); settle(); check("R3 random par"); end
      endcase
      check("R8 complementary");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule